// File: doc/BRIEF.md
# Narrow Write Beat Packer

The packer sits on a 64-bit write path between a bus slave front end and the command and write-data queue of a memory controller. Write beats narrower than the bus (one, two or four bytes) arrive already placed in the byte lanes selected by their low address bits. For a burst of known length with an incrementing address, the block gathers these beats into one register. It sends out one command carrying a complete 64-bit word and an 8-bit byte-enable mask when the top lane of the word has been written or the burst ends. Lanes that no beat wrote get a cleared enable and zero data, so a burst that starts or ends in the middle of a word produces a partial mask.

Wrapping bursts and incrementing bursts of undefined length are flagged by the front end as not mergeable. Each of their beats leaves as its own command with only its own lanes enabled. Full-width beats always leave as complete words. The output holds one command at a time, with address, data and mask together. While that command is not taken, the beat side is stalled, so commands leave in the order in which their data was written.

Top module: `narrow_write_packer`

## Requirements
- R1: After reset, out_valid is 0 and beat_ready is 1.
- R2: A beat's lane enables come from beat_size and beat_addr[2:0]. beat_size 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. The beat enables the lanes of the size-aligned group that contains the offset, for example size 1 at offset 3 enables lanes 2 and 3 (mask 8'h0C).
- R3: With beat_merge=1, accepted beats that fall in one 64-bit word are combined into a single output command. Its mask is the OR of their lane enables and each lane carries the data of the beat that wrote it, unshifted (lane k is bits 8k+7:8k).
- R4: A mergeable beat that enables lane 7 closes the word. The next beat starts a fresh word at the next word address, whose out_addr has bits 2:0 equal to zero.
- R5: A mergeable beat with beat_last=1 closes the word even if it is partial. Lanes with a cleared out_mask bit carry zero data.
- R6: With beat_merge=0, each accepted beat produces its own command whose mask is exactly that beat's lane enables and whose data is zero outside them.
- R7: A beat with beat_size 3 produces a command with mask 8'hFF.
- R8: While out_valid=1 and out_ready=0, beat_ready is 0 and out_addr, out_data and out_mask stay unchanged.
- R9: Commands leave in the order in which their beats were accepted, and at most one command is pending at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| beat_valid | input | 1 | A write beat is offered |
| beat_ready | output | 1 | Beat accepted on this edge when high (bus ready) |
| beat_addr | input | 32 | Byte address of the beat |
| beat_size | input | 2 | Log2 of bytes in the beat |
| beat_last | input | 1 | Final beat of the burst |
| beat_merge | input | 1 | 1: defined-length incrementing burst, merge allowed |
| beat_data | input | 64 | Write data, already lane-aligned |
| out_valid | output | 1 | A command with its word is pending |
| out_ready | input | 1 | Queue takes the command on this edge |
| out_addr | output | 32 | Word-aligned command address |
| out_data | output | 64 | Merged write word |
| out_mask | output | 8 | Byte enables of the word |

## Verification
The embedded assertions check on every cycle that a stalled command keeps its contents and blocks the beat side. They also check that disabled lanes carry zero data, that bypassed and full-width beats produce the masks they should, and that the gathering register never keeps a word whose top lane is written. Only the bench scenarios can show that the right beats end up in the right word: merging across a whole burst, the split of a word when a burst crosses a word boundary, partial words at burst ends, and the command order under random back-pressure. These are compared against a byte-lane reference model.

// File: rtl/nwp_pkg.sv
// Shared constants for the narrow write packer.
// Assumes byte-granular lanes on a power-of-two data path.
package nwp_pkg;
    localparam int unsigned BYTE_W = 8;

    // Number of byte lanes for a given data width.
    function automatic int unsigned lanes_of(input int unsigned data_w);
        return data_w / BYTE_W;
    endfunction
endpackage

// File: rtl/nwp_lane_decode.sv
// Turns a beat's offset and size into its byte-lane enables.
// Assumes the address is aligned to the beat size; misaligned low bits
// are ignored by taking the size-aligned group holding the offset.
module nwp_lane_decode #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned OFS_W  = $clog2(LANES),
    parameter int unsigned SIZE_W = 2
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [SIZE_W-1:0] size,
    output logic [LANES-1:0]  lane_en,
    output logic              ends_word
);
    // One comparator per lane: a lane is on when it shares the beat's size group.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFS_W-1:0] IDX = OFS_W'(i);
        always_comb lane_en[i] = ((IDX >> size) == (ofs >> size));
    end

    // A beat reaching the top lane completes the current word.
    always_comb ends_word = lane_en[LANES-1];
endmodule

// File: rtl/nwp_merge_acc.sv
// Gathering register for mergeable beats. Presents the word that would
// result from combining the current beat with what was gathered so far,
// and stores it unless the word is being closed.
// Assumes the top level closes the word before it would cross a boundary.
module nwp_merge_acc #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LANES  = DATA_W / nwp_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_acc,
    input  logic              take,
    input  logic              close,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] beat_data,
    input  logic [ADDR_W-1:0] beat_waddr,
    output logic [DATA_W-1:0] mrg_data,
    output logic [LANES-1:0]  mrg_mask,
    output logic [ADDR_W-1:0] mrg_addr
);
    localparam int unsigned BW = nwp_pkg::BYTE_W;

    logic [DATA_W-1:0] acc_data;
    logic [LANES-1:0]  acc_mask;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_act;

    // Per-lane select: new beat data, else gathered data, else zero.
    for (genvar i = 0; i < LANES; i++) begin : g_mrg
        always_comb begin
            if (lane_en[i])
                mrg_data[i*BW +: BW] = beat_data[i*BW +: BW];
            else if (use_acc)
                mrg_data[i*BW +: BW] = acc_data[i*BW +: BW];
            else
                mrg_data[i*BW +: BW] = '0;
        end
    end

    // Combined mask and the word address the command will carry.
    always_comb begin
        mrg_mask = lane_en | (use_acc ? acc_mask : '0);
        mrg_addr = (use_acc && acc_act) ? acc_addr : beat_waddr;
    end

    // Store the partial word, or clear it once it has been handed out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_data <= '0;
            acc_mask <= '0;
            acc_addr <= '0;
            acc_act  <= 1'b0;
        end else if (take) begin
            if (close) begin
                acc_data <= '0;
                acc_mask <= '0;
                acc_act  <= 1'b0;
            end else begin
                acc_data <= mrg_data;
                acc_mask <= mrg_mask;
                acc_addr <= mrg_addr;
                acc_act  <= 1'b1;
            end
        end
    end

    // An open word never holds its top lane: that lane closes it (R4).
    assert_open_word_below_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_act |-> !acc_mask[LANES-1]);
    // An open word always has at least one written lane (R3).
    assert_open_word_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_act |-> (acc_mask != '0));
endmodule

// File: rtl/nwp_out_stage.sv
// Single-entry command register holding address, word and mask together.
// Assumes the top level loads it only when it is empty or being drained.
module nwp_out_stage #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LANES  = DATA_W / nwp_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_mask,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_mask,
    output logic [ADDR_W-1:0] out_addr
);
    localparam int unsigned BW = nwp_pkg::BYTE_W;

    // Load a closed word, or drop the pending one once the queue takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_mask  <= '0;
            out_addr  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
            out_mask  <= in_mask;
            out_addr  <= in_addr;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // A refused command stays put until taken (R8).
    assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_mask) && $stable(out_addr)));
    // Every pending command writes at least one byte (R9).
    assert_mask_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask != '0));
    // Disabled lanes carry zero data (R5).
    for (genvar i = 0; i < LANES; i++) begin : g_zero_chk
        assert_idle_lane_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_mask[i]) |-> (out_data[i*BW +: BW] == '0));
    end
endmodule

// File: rtl/narrow_write_packer.sv
// Narrow write beat packer: gathers sub-width beats of mergeable bursts
// into masked full words, passes non-mergeable beats through one by one,
// and stalls the beat side while a finished command waits.
// Assumes write data is already in its byte lanes and that mergeable
// bursts increment their address without gaps.
module narrow_write_packer #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LANES  = DATA_W / nwp_pkg::BYTE_W,
    parameter int unsigned OFS_W  = $clog2(LANES),
    parameter int unsigned SIZE_W = $clog2(OFS_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    output logic              beat_ready,
    input  logic [ADDR_W-1:0] beat_addr,
    input  logic [SIZE_W-1:0] beat_size,
    input  logic              beat_last,
    input  logic              beat_merge,
    input  logic [DATA_W-1:0] beat_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_mask
);
    logic [LANES-1:0]  lane_en;
    logic              ends_word;
    logic              fire;
    logic              close;
    logic [ADDR_W-1:0] beat_waddr;
    logic [DATA_W-1:0] mrg_data;
    logic [LANES-1:0]  mrg_mask;
    logic [ADDR_W-1:0] mrg_addr;

    // Handshake and close decision for the current beat.
    always_comb begin
        beat_ready = !out_valid || out_ready;
        fire       = beat_valid && beat_ready;
        close      = !beat_merge || ends_word || beat_last;
        beat_waddr = {beat_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    end

    nwp_lane_decode #(
        .LANES (LANES),
        .OFS_W (OFS_W),
        .SIZE_W(SIZE_W)
    ) dec_i (
        .ofs      (beat_addr[OFS_W-1:0]),
        .size     (beat_size),
        .lane_en  (lane_en),
        .ends_word(ends_word)
    );

    nwp_merge_acc #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .LANES (LANES)
    ) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_acc   (beat_merge),
        .take      (fire && beat_merge),
        .close     (close),
        .lane_en   (lane_en),
        .beat_data (beat_data),
        .beat_waddr(beat_waddr),
        .mrg_data  (mrg_data),
        .mrg_mask  (mrg_mask),
        .mrg_addr  (mrg_addr)
    );

    nwp_out_stage #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .LANES (LANES)
    ) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fire && close),
        .in_data  (mrg_data),
        .in_mask  (mrg_mask),
        .in_addr  (mrg_addr),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_mask (out_mask),
        .out_addr (out_addr)
    );

    // A bypassed beat leaves alone with exactly its own lanes (R6).
    assert_bypass_own_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && fire && !beat_merge) |=> (out_valid && out_mask == $past(lane_en)));
    // A full-width beat leaves as a complete word (R7).
    assert_full_beat_all_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && fire && beat_size == SIZE_W'(OFS_W)) |=> (out_valid && (&out_mask)));
    // Commands are word-aligned (R4).
    assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr[OFS_W-1:0] == '0));
endmodule

// File: tb/narrow_write_packer_tb_top.sv
`timescale 1ns/1ps
module narrow_write_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        beat_valid, beat_ready, beat_last, beat_merge;
    logic [31:0] beat_addr;
    logic [1:0]  beat_size;
    logic [63:0] beat_data;
    logic        out_valid, out_ready;
    logic [31:0] out_addr;
    logic [63:0] out_data;
    logic [7:0]  out_mask;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    int ready_mode = 0; // 0 always ready, 1 random, 2 held low

    always #2 clk = ~clk;

    narrow_write_packer dut_i (
        .clk(clk), .rst_n(rst_n),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
        .beat_size(beat_size), .beat_last(beat_last), .beat_merge(beat_merge),
        .beat_data(beat_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_data(out_data), .out_mask(out_mask)
    );

    always @(negedge clk) begin
        case (ready_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = 1'($urandom_range(0, 1));
            default: out_ready = 1'b0;
        endcase
    end

    logic [31:0] got_a[$], exp_a[$];
    logic [63:0] got_d[$], exp_d[$];
    logic [7:0]  got_m[$], exp_m[$];

    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            got_a.push_back(out_addr);
            got_d.push_back(out_data);
            got_m.push_back(out_mask);
        end
    end

    // Reference model state: one byte-lane word being gathered.
    bit          m_act = 0;
    logic [31:0] m_addr;
    logic [63:0] m_data = '0;
    logic [7:0]  m_mask = '0;

    function automatic logic [7:0] lanes_of(input logic [2:0] ofs, input logic [1:0] sz);
        int n = 1 << sz;
        int b = int'(ofs) & ~(n - 1);
        logic [7:0] r = '0;
        for (int k = b; k < b + n; k++) r[k] = 1'b1;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic send_beat(input logic [31:0] a, input logic [1:0] sz, input bit last,
                             input bit mrg, input logic [63:0] d);
        logic [7:0]  ln = lanes_of(a[2:0], sz);
        logic [31:0] wa = {a[31:3], 3'b000};
        logic [63:0] dm = '0;
        for (int k = 0; k < 8; k++) if (ln[k]) dm[k*8 +: 8] = d[k*8 +: 8];
        if (mrg) begin
            if (!m_act) m_addr = wa;
            m_act  = 1;
            m_data = m_data | dm;
            m_mask = m_mask | ln;
            if (ln[7] || last) begin
                exp_a.push_back(m_addr); exp_d.push_back(m_data); exp_m.push_back(m_mask);
                m_act = 0; m_data = '0; m_mask = '0;
            end
        end else begin
            exp_a.push_back(wa); exp_d.push_back(dm); exp_m.push_back(ln);
        end
        forever begin
            @(negedge clk);
            beat_valid = 1; beat_addr = a; beat_size = sz;
            beat_last = last; beat_merge = mrg; beat_data = d;
            #1;
            if (beat_ready) begin
                @(posedge clk);
                break;
            end
        end
        @(negedge clk);
        beat_valid = 0;
        beat_data  = {$urandom, $urandom};
    endtask

    task automatic send_burst(input logic [31:0] start, input logic [1:0] sz, input int len,
                              input bit mrg, input bit wrap);
        int n = 1 << sz;
        int bound = len * n;
        for (int i = 0; i < len; i++) begin
            logic [31:0] a;
            if (wrap)
                a = (start & ~32'(bound - 1)) | ((start + 32'(i * n)) & 32'(bound - 1));
            else
                a = start + 32'(i * n);
            send_beat(a, sz, i == len - 1, mrg, {$urandom, $urandom});
        end
    endtask

    task automatic drain_compare(input string tag);
        int n;
        ready_mode = 0;
        repeat (6) @(negedge clk);
        check(got_a.size() == exp_a.size(), tag, "command count",
              64'(got_a.size()), 64'(exp_a.size()));
        n = (got_a.size() < exp_a.size()) ? got_a.size() : exp_a.size();
        for (int i = 0; i < n; i++) begin
            check(got_a[i] == exp_a[i], tag, "addr", 64'(got_a[i]), 64'(exp_a[i]));
            check(got_m[i] == exp_m[i], tag, "mask", 64'(got_m[i]), 64'(exp_m[i]));
            check(got_d[i] == exp_d[i], tag, "data", got_d[i], exp_d[i]);
        end
    endtask

    task automatic clear_q();
        got_a.delete(); got_d.delete(); got_m.delete();
        exp_a.delete(); exp_d.delete(); exp_m.delete();
    endtask

    // R1: idle outputs after reset.
    task automatic t_reset();
        @(negedge clk); #1;
        check(out_valid == 0, "R1", "out_valid", 64'(out_valid), 0);
        check(beat_ready == 1, "R1", "beat_ready", 64'(beat_ready), 1);
    endtask

    // R2, R3: whole word from bytes; halfword lane group from offset 2.
    task automatic t_merge();
        clear_q();
        send_burst(32'h100, 2'd0, 8, 1, 0);
        send_burst(32'h202, 2'd1, 3, 1, 0);
        send_beat(32'h303, 2'd1, 1, 1, 64'h1111_2222_3333_4444);
        drain_compare("R3");
        if (got_m.size() == 3) begin
            check(got_m[0] == 8'hFF, "R3", "byte merge mask", 64'(got_m[0]), 64'hFF);
            check(got_m[1] == 8'hFC, "R2", "half mask", 64'(got_m[1]), 64'hFC);
            check(got_m[2] == 8'h0C, "R2", "misaligned half", 64'(got_m[2]), 64'h0C);
        end
        clear_q();
    endtask

    // R4: byte burst crossing a word boundary splits into two words.
    task automatic t_cross();
        clear_q();
        send_burst(32'h405, 2'd0, 6, 1, 0);
        drain_compare("R4");
        if (got_m.size() == 2) begin
            check(got_m[0] == 8'hE0 && got_a[0] == 32'h400, "R4", "first word", 64'(got_m[0]), 64'hE0);
            check(got_m[1] == 8'h07 && got_a[1] == 32'h408, "R4", "second word", 64'(got_m[1]), 64'h07);
        end
        clear_q();
    endtask

    // R5: burst end leaves a partial word with zeroed idle lanes.
    task automatic t_partial();
        clear_q();
        send_beat(32'h504, 2'd2, 1, 1, 64'hAAAA_BBBB_CCCC_DDDD);
        send_beat(32'h602, 2'd1, 1, 1, 64'h9999_8888_7777_6666);
        drain_compare("R5");
        if (got_d.size() == 2) begin
            check(got_d[0] == 64'hAAAA_BBBB_0000_0000, "R5", "partial data",
                  got_d[0], 64'hAAAA_BBBB_0000_0000);
            check(got_d[1] == 64'h0000_0000_7777_0000, "R5", "partial data",
                  got_d[1], 64'h0000_0000_7777_0000);
        end
        clear_q();
    endtask

    // R6: non-mergeable wrapping beats each leave alone.
    task automatic t_bypass();
        clear_q();
        send_burst(32'h702, 2'd0, 4, 0, 1);
        send_burst(32'h806, 2'd1, 4, 0, 0);
        drain_compare("R6");
        check(got_m.size() == 8, "R6", "one command per beat", 64'(got_m.size()), 8);
        clear_q();
    endtask

    // R7: full-width beats are complete words.
    task automatic t_full();
        clear_q();
        send_burst(32'h900, 2'd3, 4, 1, 0);
        drain_compare("R7");
        for (int i = 0; i < got_m.size(); i++)
            check(got_m[i] == 8'hFF, "R7", "full mask", 64'(got_m[i]), 64'hFF);
        clear_q();
    endtask

    // R8: a refused command blocks beats and stays unchanged.
    task automatic t_stall();
        logic [63:0] d0;
        logic [7:0]  m0;
        clear_q();
        ready_mode = 2;
        send_burst(32'hA00, 2'd0, 8, 1, 0);
        #1;
        check(out_valid == 1, "R8", "pending", 64'(out_valid), 1);
        check(beat_ready == 0, "R8", "beat side stalled", 64'(beat_ready), 0);
        d0 = out_data; m0 = out_mask;
        repeat (3) @(negedge clk);
        #1;
        check(out_data == d0 && out_mask == m0 && out_valid, "R8", "held word", out_data, d0);
        check(beat_ready == 0, "R8", "still stalled", 64'(beat_ready), 0);
        drain_compare("R8");
        clear_q();
    endtask

    // R9: random bursts under random back-pressure keep order and content.
    task automatic t_random();
        clear_q();
        ready_mode = 1;
        for (int b = 0; b < 40; b++) begin
            logic [1:0]  sz  = 2'($urandom_range(0, 3));
            bit          mrg = 1'($urandom_range(0, 3) != 0);
            int          len = mrg ? int'($urandom_range(1, 16)) : (4 << $urandom_range(0, 2));
            logic [31:0] st  = (32'h1000 + 32'(b) * 32'h100 + 32'($urandom_range(0, 7)))
                               & ~32'((1 << sz) - 1);
            send_burst(st, sz, len, mrg, !mrg);
            ready_mode = 1;
        end
        drain_compare("R9");
        clear_q();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; beat_valid = 0; beat_addr = '0; beat_size = '0;
        beat_last = 0; beat_merge = 0; beat_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_merge();
        t_cross();
        t_partial();
        t_bypass();
        t_full();
        t_stall();
        t_random();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule